// File: doc/BRIEF.md
# UART Interrupt Source Controller

This block turns the status of a UART's transmit and receive paths into interrupt requests. Its inputs are the transmit and receive FIFO fill counts, the FIFO-enable mode, the single-register flags used when the FIFOs are off, the flow-control input pins, a one-cycle bit-period tick and a per-source enable mask. It drives a transmit line, a receive line and one combined line. A four-bit identification value on a minimal register port lets software see which gated sources are active. Any write strobe to that register drops a pending modem-status request.

The logic is built around three small state machines and one combinational source:

- **Transmit source** has states `TX_OFF` and `TX_ON`. It follows the current raw transmit request, and in FIFO mode that state supplies the hold value at exactly half full.
- **Modem source** has states `MS_ARM`, `MS_QUIET` and `MS_PEND`. After reset, `MS_ARM` only captures the pins. `MS_QUIET` moves to `MS_PEND` when a pin changes. `MS_PEND` returns to `MS_QUIET` on a clear strobe, but only if no change arrives in that same cycle.
- **Receive timeout** has states `TO_IDLE`, `TO_COUNT` and `TO_FIRED`. `TO_IDLE` moves to `TO_COUNT` when the receive count becomes non-zero. `TO_COUNT` moves to `TO_FIRED` on the 32nd tick that arrives without a push. `TO_COUNT` and `TO_FIRED` both return to `TO_IDLE` when the count reaches zero.
- **Receive source** is combinational.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, with all status inputs quiet, all output lines and `id_rdata` are 0. The modem source ignores the pin values seen in the first cycle after reset.
- R2: In FIFO mode (depth 16, half = 8), the raw transmit request is 1 for `tx_level` < 8 and 0 for `tx_level` > 8. At exactly 8 it keeps the value it had in the previous cycle. It reacts combinationally to the level.
- R3: With FIFOs disabled, the raw transmit request equals `hold_empty`.
- R4: In FIFO mode, the raw receive request is 1 exactly when `rx_level` >= 8.
- R5: With FIFOs disabled, the raw receive request equals `rx_full`.
- R6: Any change of `flow_in` between consecutive cycles sets the modem request. The request is visible after the next clock edge.
- R7: A cycle with `id_wr` or `msr_wr` high clears the modem request at the next edge. If `flow_in` changes in that same cycle, the request stays set.
- R8: While `rx_level` is non-zero, the timeout request rises after the edge of the 32nd `bit_tick` counted since the FIFO became non-empty or since the last `rx_push`. A push in the same cycle as a tick restarts the count, and that tick is not counted.
- R9: The timeout request falls at the edge after `rx_level` becomes 0. A push does not clear an already raised timeout.
- R10: `id_rdata` bit 0 is modem, bit 1 is receive, bit 2 is transmit and bit 3 is timeout. Each bit is its raw request ANDed with the same bit of `irq_en`. `tx_irq` equals bit 2 and `rx_irq` equals bit 1.
- R11: `any_irq` is 1 exactly when at least one bit of `id_rdata` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_en | input | 1 | 1 selects FIFO mode |
| tx_level | input | 5 | Transmit FIFO entry count, 0..16 |
| hold_empty | input | 1 | Transmit holding register empty (non-FIFO mode) |
| rx_level | input | 5 | Receive FIFO entry count, 0..16 |
| rx_full | input | 1 | Receive buffer full (non-FIFO mode) |
| rx_push | input | 1 | A character entered the receive FIFO this cycle |
| flow_in | input | 2 | Flow-control input pins |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| irq_en | input | 4 | Per-source enable, same bit order as `id_rdata` |
| msr_wr | input | 1 | Write strobe to the modem status register |
| id_wr | input | 1 | Write strobe to the identification register |
| id_rdata | output | 4 | Identification register read value (gated sources) |
| tx_irq | output | 1 | Transmit interrupt line |
| rx_irq | output | 1 | Receive interrupt line |
| any_irq | output | 1 | Combined interrupt line |

## Verification
Two pairs of events can fall in the same cycle. In the first, a flow-pin change meets a clear strobe. The bench drives a pin change and `id_wr` in one cycle and expects the modem bit to survive. In the second, a receive push meets the tick that would complete the timeout. The bench runs 31 ticks, then raises `rx_push` with the 32nd. It expects no timeout at that point, and a timeout exactly 32 further ticks later. Around these cases, the bench sweeps the transmit and receive levels in both directions and all 16 enable masks, and compares each result with values worked out in the bench itself.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [1:0] {
        MS_ARM   = 2'd0,
        MS_QUIET = 2'd1,
        MS_PEND  = 2'd2
    } ms_state_t;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_t;

    typedef enum logic {
        TX_OFF = 1'b0,
        TX_ON  = 1'b1
    } tx_state_t;

    localparam int SRC_MODEM = 0;
    localparam int SRC_RX    = 1;
    localparam int SRC_TX    = 2;
    localparam int SRC_TO    = 3;
    localparam int NUM_SRC   = 4;

endpackage

// File: rtl/uirq_tx_src.sv
module uirq_tx_src
    import uart_irq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fifo_en,
    input  logic [LW-1:0] level,
    input  logic          hold_empty,
    output logic          req
);

    localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

    tx_state_t state_q;
    tx_state_t state_d;
    logic      fifo_req;

    // FIFO mode: below half requests, above half releases, at half holds
    always_comb begin
        if (level < HALF_L) begin
            fifo_req = 1'b1;
        end else if (level > HALF_L) begin
            fifo_req = 1'b0;
        end else begin
            fifo_req = (state_q == TX_ON);
        end
    end

    // output process
    always_comb begin
        req = fifo_en ? fifo_req : hold_empty;
    end

    // next-state process
    always_comb begin
        unique case (state_q)
            TX_OFF:  state_d = req ? TX_ON : TX_OFF;
            TX_ON:   state_d = req ? TX_ON : TX_OFF;
            default: state_d = TX_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TX_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // R2
    tx_hold_at_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && level == HALF_L && $past(fifo_en) && $past(level) == HALF_L)
            |-> (req == $past(req)));

endmodule

// File: rtl/uirq_modem_src.sv
module uirq_modem_src
    import uart_irq_pkg::*;
#(
    parameter int FW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [FW-1:0] flow_in,
    input  logic          clr,
    output logic          req
);

    ms_state_t     state_q;
    ms_state_t     state_d;
    logic [FW-1:0] flow_q;
    logic          changed;

    assign changed = (flow_in != flow_q);

    // next-state process
    always_comb begin
        unique case (state_q)
            MS_ARM:   state_d = MS_QUIET;
            MS_QUIET: state_d = changed ? MS_PEND : MS_QUIET;
            MS_PEND:  state_d = (clr && !changed) ? MS_QUIET : MS_PEND;
            default:  state_d = MS_ARM;
        endcase
    end

    // state register and pin history
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MS_ARM;
            flow_q  <= '0;
        end else begin
            state_q <= state_d;
            flow_q  <= flow_in;
        end
    end

    // output process
    always_comb begin
        req = (state_q == MS_PEND);
    end

    // R6
    ms_change_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MS_ARM && flow_in != $past(flow_in)) |=> req);

    // R7
    ms_clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != MS_ARM && clr && flow_in == $past(flow_in)) |=> !req);

endmodule

// File: rtl/uirq_rx_timeout.sv
module uirq_rx_timeout
    import uart_irq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TO_BITS = 32,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int CW = $clog2(TO_BITS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic          push,
    input  logic          tick,
    output logic          req
);

    localparam logic [CW-1:0] LAST_C = CW'(TO_BITS - 1);

    to_state_t     state_q;
    to_state_t     state_d;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;
    logic          empty;

    assign empty = (level == '0);

    // next-state and counter process
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TO_IDLE: begin
                cnt_d = '0;
                if (!empty) begin
                    state_d = TO_COUNT;
                end
            end
            TO_COUNT: begin
                if (empty) begin
                    state_d = TO_IDLE;
                    cnt_d   = '0;
                end else if (push) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST_C) begin
                        state_d = TO_FIRED;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            TO_FIRED: begin
                cnt_d = '0;
                if (empty) begin
                    state_d = TO_IDLE;
                end
            end
            default: begin
                state_d = TO_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // output process
    always_comb begin
        req = (state_q == TO_FIRED);
    end

    // R9
    to_empty_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> !req);

    // R9
    to_fired_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !empty) |=> req);

    // R8
    to_push_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && push) |=> !req);

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uart_irq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int TO_BITS = 32,
    parameter int FW      = 2,
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_en,
    input  logic [LW-1:0]      tx_level,
    input  logic               hold_empty,
    input  logic [LW-1:0]      rx_level,
    input  logic               rx_full,
    input  logic               rx_push,
    input  logic [FW-1:0]      flow_in,
    input  logic               bit_tick,
    input  logic [NUM_SRC-1:0] irq_en,
    input  logic               msr_wr,
    input  logic               id_wr,
    output logic [NUM_SRC-1:0] id_rdata,
    output logic               tx_irq,
    output logic               rx_irq,
    output logic               any_irq
);

    localparam logic [LW-1:0] HALF_L = LW'(DEPTH / 2);

    logic [NUM_SRC-1:0] raw;

    uirq_tx_src #(.DEPTH(DEPTH)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_en    (fifo_en),
        .level      (tx_level),
        .hold_empty (hold_empty),
        .req        (raw[SRC_TX])
    );

    uirq_modem_src #(.FW(FW)) u_ms (
        .clk     (clk),
        .rst_n   (rst_n),
        .flow_in (flow_in),
        .clr     (id_wr | msr_wr),
        .req     (raw[SRC_MODEM])
    );

    uirq_rx_timeout #(.DEPTH(DEPTH), .TO_BITS(TO_BITS)) u_to (
        .clk   (clk),
        .rst_n (rst_n),
        .level (rx_level),
        .push  (rx_push),
        .tick  (bit_tick),
        .req   (raw[SRC_TO])
    );

    // receive source: threshold in FIFO mode, buffer flag otherwise
    always_comb begin
        raw[SRC_RX] = fifo_en ? (rx_level >= HALF_L) : rx_full;
    end

    // per-source gating into the identification value
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        assign id_rdata[g] = raw[g] & irq_en[g];
    end

    assign tx_irq  = id_rdata[SRC_TX];
    assign rx_irq  = id_rdata[SRC_RX];
    assign any_irq = |id_rdata;

    // R2
    tx_above_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_en && tx_level > HALF_L) |-> !tx_irq);

    // R5
    rx_nofifo_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en && !rx_full) |-> !rx_irq);

    // R11
    any_needs_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_irq |-> (irq_en != '0));

endmodule

// File: tb/uart_irq_ctrl_test.sv
`timescale 1ns/100ps
module uart_irq_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fifo_en = 1'b0;
    logic [4:0] tx_level = '0;
    logic       hold_empty = 1'b0;
    logic [4:0] rx_level = '0;
    logic       rx_full = 1'b0;
    logic       rx_push = 1'b0;
    logic [1:0] flow_in = '0;
    logic       bit_tick = 1'b0;
    logic [3:0] irq_en = '0;
    logic       msr_wr = 1'b0;
    logic       id_wr = 1'b0;
    logic [3:0] id_rdata;
    logic       tx_irq, rx_irq, any_irq;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    uart_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_level(tx_level),
        .hold_empty(hold_empty), .rx_level(rx_level), .rx_full(rx_full),
        .rx_push(rx_push), .flow_in(flow_in), .bit_tick(bit_tick),
        .irq_en(irq_en), .msr_wr(msr_wr), .id_wr(id_wr), .id_rdata(id_rdata),
        .tx_irq(tx_irq), .rx_irq(rx_irq), .any_irq(any_irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            bit_tick = 1'b1;
            cyc();
            bit_tick = 1'b0;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic prev;
        logic e;

        flow_in = 2'b10;
        repeat (3) cyc();
        rst_n = 1'b1;
        #1;
        // R1: quiet after reset, pins seen in first cycle ignored
        irq_en = 4'hF;
        #1;
        chk("R1", id_rdata, 4'h0);
        cyc();
        cyc();
        chk("R1", {any_irq, tx_irq, rx_irq, id_rdata[0]}, 4'h0);

        // R6: pin change sets modem bit after the edge
        flow_in = 2'b11;
        #1;
        chk("R6", id_rdata, 4'h0);
        cyc();
        chk("R6", id_rdata, 4'b0001);
        chk("R11", {3'b0, any_irq}, 4'h1);
        // R7: id write clears
        id_wr = 1'b1;
        cyc();
        id_wr = 1'b0;
        chk("R7", id_rdata, 4'h0);
        // R7: change in same cycle as clear wins
        flow_in = 2'b01;
        id_wr = 1'b1;
        cyc();
        id_wr = 1'b0;
        chk("R7", id_rdata, 4'b0001);
        cyc();
        chk("R7", id_rdata, 4'b0001);
        msr_wr = 1'b1;
        cyc();
        msr_wr = 1'b0;
        chk("R7", id_rdata, 4'h0);

        // R8: timeout after 32 ticks
        fifo_en = 1'b1;
        tx_level = 5'd16;
        rx_level = 5'd3;
        cyc();
        ticks(31);
        chk("R8", id_rdata, 4'h0);
        ticks(1);
        chk("R8", id_rdata, 4'b1000);
        rx_level = 5'd0;
        cyc();
        chk("R9", id_rdata, 4'h0);
        // R8: push together with the 32nd tick restarts count
        rx_level = 5'd3;
        cyc();
        ticks(31);
        rx_push = 1'b1;
        bit_tick = 1'b1;
        cyc();
        rx_push = 1'b0;
        bit_tick = 1'b0;
        chk("R8", id_rdata, 4'h0);
        ticks(31);
        chk("R8", id_rdata, 4'h0);
        ticks(1);
        chk("R8", id_rdata, 4'b1000);
        // R9: push does not clear a raised timeout
        rx_push = 1'b1;
        cyc();
        rx_push = 1'b0;
        chk("R9", id_rdata, 4'b1000);

        // R10/R11: all sources raw-high, sweep every enable mask
        rx_level = 5'd9;
        tx_level = 5'd0;
        flow_in = 2'b00;
        cyc();
        for (int m = 0; m < 16; m++) begin
            irq_en = 4'(m);
            #1;
            chk("R10", id_rdata, 4'(m));
            chk("R10", {2'b0, tx_irq, rx_irq}, {2'b0, 1'(m >> 2), 1'(m >> 1)});
            chk("R11", {3'b0, any_irq}, {3'b0, (m != 0)});
        end
        irq_en = 4'hF;
        rx_level = 5'd0;
        id_wr = 1'b1;
        cyc();
        id_wr = 1'b0;
        chk("R9", id_rdata[3:0] & 4'b1001, 4'h0);

        // R2: tx level sweep up then down with hysteresis at half
        tx_level = 5'd16;
        cyc();
        prev = 1'b0;
        for (int l = 0; l <= 16; l++) begin
            tx_level = 5'(l);
            #1;
            e = (l < 8) || (l == 8 && prev);
            chk("R2", {3'b0, tx_irq}, {3'b0, e});
            cyc();
            prev = e;
        end
        for (int l = 16; l >= 0; l--) begin
            tx_level = 5'(l);
            #1;
            e = (l < 8) || (l == 8 && prev);
            chk("R2", {3'b0, tx_irq}, {3'b0, e});
            cyc();
            prev = e;
        end

        // R4: rx threshold sweep
        tx_level = 5'd16;
        for (int l = 0; l <= 16; l++) begin
            rx_level = 5'(l);
            #1;
            chk("R4", {3'b0, rx_irq}, {3'b0, (l >= 8)});
        end
        rx_level = 5'd0;
        cyc();

        // R3/R5: non-FIFO mode flags
        fifo_en = 1'b0;
        for (int c = 0; c < 4; c++) begin
            hold_empty = c[0];
            rx_full = c[1];
            #1;
            chk("R3", {3'b0, tx_irq}, {3'b0, c[0]});
            chk("R5", {3'b0, rx_irq}, {3'b0, c[1]});
            chk("R11", {3'b0, any_irq}, {3'b0, (c != 0)});
            cyc();
        end

        finish_run();
    end

endmodule